// File: doc/BRIEF.md
# Per-Row SDRAM Command Broadcaster

This block takes a single memory-initialisation command and spreads it across every populated row of an SDRAM array. Eight rows are handled, two per socket across four sockets. Software describes the array as a table of cumulative row-end values in 8 MiB units. The block walks that table in ascending row order. For each row whose end lies above its start, it issues one read-style access to the row's base address plus a command-specific offset. It raises a one-cycle done pulse once the last row has been handled.

The mode-register-set command encodes the mode word in the low address bits. The offset for that command therefore depends on the CAS latency. It also depends on whether the row sits in the lower or the upper half of the array, because the upper sockets see some address lines inverted. Every other command uses a zero offset. The "normal operation" command only changes controller state, so it finishes without touching any row.

Top module: `row_cmd_broadcast`

## Requirements
- R1: After reset, accValid, done and busy are all low.
- R2: Command codes are 0 normal, 1 no-op, 2 precharge-all, 3 mode-register-set and 4 refresh; codes 5 to 7 are treated like any other non-mode command. A normal command (code 0) makes no access, and done is high in the cycle after the command is taken.
- R3: Rows are visited in order 0 to 7. Each non-empty row gets exactly one access at address rowStart * 2^23 + offset. rowStart is 0 for row 0 and the table value of the previous row for every other row.
- R4: A row whose table value is not strictly greater than its start is skipped with no access. The start of the next row still becomes that table value.
- R5: For code 3 with casIsThree = 1, the offset is 0x1D0 for rows 0 to 3 and 0x1E28 for rows 4 to 7.
- R6: For code 3 with casIsThree = 0, the offset is 0x150 for rows 0 to 3 and 0x1EA8 for rows 4 to 7.
- R7: For every code other than 3, the offset is zero.
- R8: While accValid is high and accReady is low, accValid stays high and accAddr stays unchanged in the next cycle.
- R9: After all eight rows have been handled, done is high for exactly one cycle. busy is low in that cycle, and no access is issued between done and the next command.
- R10: cmdValid is ignored while busy is high. The command in flight keeps its code, latency and row walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request, taken when busy is low |
| cmdCode | input | 3 | Command code (see R2) |
| casIsThree | input | 1 | 1 selects CAS latency 3, 0 selects latency 2 |
| busy | output | 1 | A command is being broadcast |
| tblIdx | output | 3 | Row index presented to the boundary table |
| tblData | input | 8 | Cumulative row-end value for row tblIdx, same cycle |
| accValid | output | 1 | Access request for the current row |
| accAddr | output | 32 | Byte address of the access |
| accReady | input | 1 | Access acknowledge |
| done | output | 1 | One-cycle pulse when the broadcast is over |

## Verification
Random cumulative tables mix growing, flat and shrinking boundaries, so populated rows, empty rows and rows whose end lies below their start are all covered. The shrinking cases separate a strict from a non-strict compare, and they also show whether the start follows the table on skipped rows. Directed cases cover a fully populated array, an empty array, only row 7 populated, and every mode-register-set latency and half combination, which exposes any mix-up of offsets or halves. The acknowledge is withheld at random, and a second request is injected mid-walk, to test that the access holds and that the command in flight is not disturbed.

// File: rtl/rowcmd_pkg.sv
package rowcmd_pkg;
  localparam int BOUND_W    = 8;
  localparam int ADDR_W     = 32;
  localparam int UNIT_SHIFT = 23;
  localparam int CODE_W     = 3;

  localparam logic [CODE_W-1:0] CMD_NORMAL = 3'd0;
  localparam logic [CODE_W-1:0] CMD_MODE   = 3'd3;

  localparam logic [ADDR_W-1:0] OFS_LO_CL3 = 32'h0000_01D0;
  localparam logic [ADDR_W-1:0] OFS_HI_CL3 = 32'h0000_1E28;
  localparam logic [ADDR_W-1:0] OFS_LO_CL2 = 32'h0000_0150;
  localparam logic [ADDR_W-1:0] OFS_HI_CL2 = 32'h0000_1EA8;

  typedef struct packed {
    logic start;    // latch command, clear row start
    logic capture;  // latch row end and access address
    logic skip;     // empty row: start <= table value
    logic step;     // acknowledged row: start <= latched end
  } ctrlStrobes_t;
endpackage

// File: rtl/rowcmd_ctrl.sv
module rowcmd_ctrl
  import rowcmd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  localparam int IDX_W = $clog2(NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [CODE_W-1:0] cmdCode,
  input  logic              nonEmpty,
  input  logic              accReady,
  output ctrlStrobes_t      strobes,
  output logic [IDX_W-1:0]  rowIdx,
  output logic              accValid,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_ACCESS} state_t;

  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(NUM_ROWS - 1);

  state_t state, stateNext;
  logic rowDone, lastRow;

  assign lastRow  = (rowIdx == LAST_ROW);
  assign accValid = (state == ST_ACCESS);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobes   = '0;
    stateNext = state;
    rowDone   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          strobes.start = 1'b1;
          if (cmdCode != CMD_NORMAL) stateNext = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (nonEmpty) begin
          strobes.capture = 1'b1;
          stateNext = ST_ACCESS;
        end else begin
          strobes.skip = 1'b1;
          rowDone = 1'b1;
        end
      end
      ST_ACCESS: begin
        if (accReady) begin
          strobes.step = 1'b1;
          rowDone = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (rowDone) stateNext = lastRow ? ST_IDLE : ST_SCAN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rowIdx <= '0;
      done   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (rowDone && lastRow) ||
               (state == ST_IDLE && cmdValid && cmdCode == CMD_NORMAL);
      if (strobes.start)      rowIdx <= '0;
      else if (rowDone && !lastRow) rowIdx <= rowIdx + 1'b1;
    end
  end
endmodule

// File: rtl/rowcmd_dpath.sv
module rowcmd_dpath
  import rowcmd_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  localparam int IDX_W = $clog2(NUM_ROWS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [CODE_W-1:0]  cmdCode,
  input  logic               casIsThree,
  input  logic [IDX_W-1:0]   rowIdx,
  input  logic [BOUND_W-1:0] tblData,
  output logic               nonEmpty,
  output logic [ADDR_W-1:0]  accAddr
);
  localparam logic [IDX_W-1:0] HALF_ROW = IDX_W'(NUM_ROWS / 2);

  logic [CODE_W-1:0]  cmdReg;
  logic               casReg;
  logic [BOUND_W-1:0] rowStart, rowEnd;
  logic [ADDR_W-1:0]  offset, rowBase;

  assign nonEmpty = (tblData > rowStart);
  assign rowBase  = ADDR_W'(rowStart) << UNIT_SHIFT;

  always_comb begin
    offset = '0;
    if (cmdReg == CMD_MODE) begin
      if (rowIdx >= HALF_ROW) offset = casReg ? OFS_HI_CL3 : OFS_HI_CL2;
      else                    offset = casReg ? OFS_LO_CL3 : OFS_LO_CL2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= '0;
      casReg   <= 1'b0;
      rowStart <= '0;
      rowEnd   <= '0;
      accAddr  <= '0;
    end else begin
      if (strobes.start) begin
        cmdReg   <= cmdCode;
        casReg   <= casIsThree;
        rowStart <= '0;
      end
      if (strobes.capture) begin
        rowEnd  <= tblData;
        accAddr <= rowBase + offset;
      end
      if (strobes.skip) rowStart <= tblData;
      if (strobes.step) rowStart <= rowEnd;
    end
  end
endmodule

// File: rtl/row_cmd_broadcast.sv
module row_cmd_broadcast
  import rowcmd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [CODE_W-1:0]  cmdCode,
  input  logic               casIsThree,
  output logic               busy,
  output logic [2:0]         tblIdx,
  input  logic [BOUND_W-1:0] tblData,
  output logic               accValid,
  output logic [ADDR_W-1:0]  accAddr,
  input  logic               accReady,
  output logic               done
);
  localparam int NUM_ROWS = 8;

  ctrlStrobes_t strobes;
  logic         nonEmpty;

  rowcmd_ctrl #(.NUM_ROWS(NUM_ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .nonEmpty(nonEmpty), .accReady(accReady), .strobes(strobes),
    .rowIdx(tblIdx), .accValid(accValid), .busy(busy), .done(done)
  );

  rowcmd_dpath #(.NUM_ROWS(NUM_ROWS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdCode(cmdCode),
    .casIsThree(casIsThree), .rowIdx(tblIdx), .tblData(tblData),
    .nonEmpty(nonEmpty), .accAddr(accAddr)
  );
endmodule

// File: rtl/rowcmd_checker.sv
module rowcmd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic [2:0]  tblIdx,
  input logic        accValid,
  input logic [31:0] accAddr,
  input logic        accReady,
  input logic        done
);
  assert_hold_access_R8: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !accReady |=> accValid && $stable(accAddr));

  assert_row_fixed_R8: assert property (@(posedge clk) disable iff (!rstN)
    accValid && !accReady |=> $stable(tblIdx));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !accValid);

  assert_access_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> busy);

  assert_gap_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> accAddr[22:13] == 10'd0);
endmodule

bind row_cmd_broadcast rowcmd_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .tblIdx(tblIdx),
  .accValid(accValid), .accAddr(accAddr), .accReady(accReady), .done(done)
);

// File: tb/row_cmd_broadcast_tb.sv
module row_cmd_broadcast_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdCode = '0;
  logic        casIsThree = 1'b0;
  logic        busy;
  logic [2:0]  tblIdx;
  logic [7:0]  tblData;
  logic        accValid;
  logic [31:0] accAddr;
  logic        accReady = 1'b0;
  logic        done;

  logic [7:0]  bound [8];
  logic [31:0] expAddr [8];
  int          expCnt;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign tblData = bound[tblIdx];

  row_cmd_broadcast u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .casIsThree(casIsThree), .busy(busy), .tblIdx(tblIdx), .tblData(tblData),
    .accValid(accValid), .accAddr(accAddr), .accReady(accReady), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modeOffset(input logic [2:0] code, input bit cl3, input int row);
    if (code != 3'd3) return 32'h0;                   // R7
    if (row < 4) return cl3 ? 32'h1D0 : 32'h150;      // R5 / R6
    return cl3 ? 32'h1E28 : 32'h1EA8;
  endfunction

  task automatic buildExpected(input logic [2:0] code, input bit cl3);
    logic [7:0] start = 8'd0;
    expCnt = 0;
    if (code == 3'd0) return;                         // R2
    for (int r = 0; r < 8; r++) begin
      if (bound[r] > start) begin                     // R4 strict compare
        expAddr[expCnt] = ({24'd0, start} << 23) + modeOffset(code, cl3, r);
        expCnt++;
      end
      start = bound[r];
    end
  endtask

  task automatic runCmd(input logic [2:0] code, input bit cl3, input int readyPct, input bit inject);
    int got = 0;
    int doneSeen = 0;
    bit finished = 1'b0;
    bit prevWait = 1'b0;
    logic [31:0] prevAddr = '0;
    buildExpected(code, cl3);
    @(negedge clk);
    cmdCode = code; casIsThree = cl3; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    if (code == 3'd0) begin
      chk(done === 1'b1 && accValid === 1'b0, "R2 normal done", {30'd0, done, accValid}, 32'h2);
      @(negedge clk);
      chk(done === 1'b0, "R9 normal pulse", {31'd0, done}, 32'h0);
      return;
    end
    for (int cyc = 0; cyc < 400 && !finished; cyc++) begin
      if (inject && cyc == 2) begin                   // R10
        cmdValid = 1'b1; cmdCode = 3'd0; casIsThree = ~cl3;
      end else begin
        cmdValid = 1'b0;
      end
      if (prevWait) begin
        chk(accValid === 1'b1 && accAddr === prevAddr, "R8 hold", accAddr, prevAddr);
      end
      if (done) begin
        doneSeen++;
        chk(busy === 1'b0, "R9 idle at done", {31'd0, busy}, 32'h0);
        finished = 1'b1;
      end
      accReady = (($urandom % 100) < readyPct);
      if (accValid) begin
        if (accReady) begin
          if (got < expCnt)
            chk(accAddr === expAddr[got], "R3 address", accAddr, expAddr[got]);
          got++;
        end
        prevWait = !accReady;
        prevAddr = accAddr;
      end else begin
        prevWait = 1'b0;
      end
      @(negedge clk);
    end
    cmdValid = 1'b0;
    accReady = 1'b0;
    chk(finished, "R9 done seen", {31'd0, finished}, 32'h1);
    chk(got == expCnt, "R4 access count", got, expCnt);
    repeat (3) begin
      chk(done === 1'b0 && accValid === 1'b0, "R9 quiet after done", {30'd0, done, accValid}, 32'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) bound[r] = 8'd0;
    repeat (3) @(negedge clk);
    chk(accValid === 1'b0 && done === 1'b0 && busy === 1'b0, "R1 reset",
        {29'd0, accValid, done, busy}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Fully populated, each row 2 units: R3, R5, R6, R7
    for (int r = 0; r < 8; r++) bound[r] = 8'(2 * (r + 1));
    runCmd(3'd3, 1'b1, 100, 1'b0);   // R5
    runCmd(3'd3, 1'b0, 60, 1'b0);    // R6
    runCmd(3'd1, 1'b1, 50, 1'b0);    // R7 no-op
    runCmd(3'd4, 1'b0, 30, 1'b1);    // R7 refresh, R10 injected request
    runCmd(3'd0, 1'b1, 100, 1'b0);   // R2 normal

    // Empty array: R4
    for (int r = 0; r < 8; r++) bound[r] = 8'd0;
    runCmd(3'd2, 1'b1, 100, 1'b0);

    // Only row 7 populated: R4, R6 upper half
    for (int r = 0; r < 7; r++) bound[r] = 8'd0;
    bound[7] = 8'd4;
    runCmd(3'd3, 1'b0, 70, 1'b0);

    // Shrinking boundary: row 2 below start, start still follows (R4)
    bound[0] = 8'd4; bound[1] = 8'd8; bound[2] = 8'd3; bound[3] = 8'd5;
    bound[4] = 8'd5; bound[5] = 8'd9; bound[6] = 8'd9; bound[7] = 8'd10;
    runCmd(3'd3, 1'b1, 80, 1'b1);

    // Random cumulative tables
    for (int t = 0; t < 40; t++) begin
      logic [7:0] acc = 8'd0;
      for (int r = 0; r < 8; r++) begin
        int kind = $urandom % 6;
        if (kind == 0 && acc > 0) acc = acc - 8'd1;
        else if (kind != 1) acc = acc + 8'($urandom % 4);
        bound[r] = acc;
      end
      runCmd(3'($urandom % 8), 1'($urandom % 2), 20 + int'($urandom % 80), (t % 5) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule